// File: doc/BRIEF.md
# Transmit Self-Test Character Source

This block sits in front of the character encoder of one transmit channel. In normal operation it forwards the user character (an 8-bit value plus a 2-bit control code) to the encoder one character clock later. When the channel's self-test enable latch is set through the configuration port, the user inputs stop having any effect. The block then emits a repeating pseudo-random stream. A receiver that runs an identical generator can check that stream.

The stream comes from a 9-bit maximal-length LFSR that restarts from a fixed seed at the start of every pass. Each state is sent either as a data byte or as a special/violation code selector, so one pass reaches every data byte and every non-zero special code. When the receivers run in reference-clock mode, each pass begins with 16 word-sync characters so that the far-end elasticity buffer can align. In that mode the seed character itself is skipped, which makes a pass 526 characters long. A one-cycle pulse marks the first character of every pass.

Top module: `bist_txgen`

## Requirements
- R1: `cfg_en` is loaded into the enable latch on a clock edge where `cfg_we` is high. On any other edge the latch keeps its value. `bist_on` shows the latch.
- R2: While `rst_n` is low, the latch is cleared and `bist_on`, `tx_char`, `tx_ctl` and `pass_start` are all zero.
- R3: While the latch is clear, `tx_char`/`tx_ctl` equal `usr_data`/`usr_ctl` as sampled at the previous clock edge.
- R4: While the latch is set, `usr_data` and `usr_ctl` have no effect on any output.
- R5: The generator state s starts at 9'h001 and steps as s' = {s[7:0], s[8]^s[4]}. `tx_char` = s[7:0]. `tx_ctl` = 2'b00 (data byte) when s[8]=1, and 2'b10 (special code selector) when s[8]=0.
- R6: Without the preamble, a pass is 511 characters and then repeats from the seed. One pass shows all 256 data bytes and all 255 special codes 1..255.
- R7: With `refclk_mode` high at the start of a pass, the pass begins with 16 characters having `tx_ctl`=2'b11 and `tx_char`=8'hBC. The generator then continues from the state after the seed, for 526 characters in total.
- R8: `pass_start` is high for exactly the first character of every pass (the first preamble character, or otherwise the seed character), and low at all other times.
- R9: Clearing the latch returns the user path at the next character. A later enable restarts from the beginning of a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe for the enable latch |
| cfg_en | input | 1 | Enable value written by `cfg_we` |
| refclk_mode | input | 1 | Receivers use reference-clock mode; add the sync preamble |
| usr_data | input | 8 | User character byte |
| usr_ctl | input | 2 | User control code |
| tx_char | output | 8 | Character byte toward the encoder |
| tx_ctl | output | 2 | Control code: 00 data, 10 special, 11 word sync |
| bist_on | output | 1 | Self-test latch state |
| pass_start | output | 1 | First character of a self-test pass |

## Verification
The user path is driven with a table of byte and control patterns, including all-zero, all-one and alternating values, so that a dropped or swapped bit shows up at the output one cycle later. A full plain pass is compared character by character with an independent polynomial model while the user inputs toggle. This separates a wrong tap, a wrong seed or a wrong data/special split, and leakage of user traffic. Coverage counts over that pass confirm all 256 data bytes and 255 special codes, and the return of the seed after 511 characters. A preamble pass checks the 16 sync characters, the skipped seed and the 526-character period. A mid-pass disable followed by a re-enable checks the return to user traffic and the restart from the seed.

// File: rtl/bist_txgen_pkg.sv
package bist_txgen_pkg;
  localparam logic [1:0] CTL_DATA = 2'b00;
  localparam logic [1:0] CTL_SPEC = 2'b10;
  localparam logic [1:0] CTL_SYNC = 2'b11;
  localparam logic [7:0] SYNC_CHAR = 8'hBC;

  typedef enum logic {PH_RUN = 1'b0, PH_PRE = 1'b1} phase_t;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int W = 9,
  parameter int TAP = 5,
  parameter logic [W-1:0] SEED = 9'h001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_seed,
  input  logic         step_en,
  output logic [W-1:0] state,
  output logic         wrap
);
  logic [W-1:0] state_q, state_step, state_d;

  assign state_step = {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};
  assign wrap = (state_step == SEED);

  always_comb begin
    state_d = state_q;
    if (load_seed)    state_d = SEED;
    else if (step_en) state_d = state_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/bist_pre_cnt.sv
module bist_pre_cnt #(
  parameter int LEN = 16,
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  output logic first,
  output logic last
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == CW'(LEN - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bist_char_map.sv
module bist_char_map #(
  parameter int W = 9,
  localparam int CW = W - 1
) (
  input  logic [W-1:0]  state,
  output logic [CW-1:0] code,
  output logic [1:0]    ctl
);
  import bist_txgen_pkg::*;

  assign code = state[CW-1:0];
  assign ctl  = state[W-1] ? CTL_DATA : CTL_SPEC;
endmodule

// File: rtl/bist_txgen.sv
module bist_txgen #(
  parameter int DW = 8,
  parameter int TAP = 5,
  parameter int PRE_LEN = 16,
  parameter logic [DW:0] SEED = 9'h001,
  localparam int LW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_en,
  input  logic          refclk_mode,
  input  logic [DW-1:0] usr_data,
  input  logic [1:0]    usr_ctl,
  output logic [DW-1:0] tx_char,
  output logic [1:0]    tx_ctl,
  output logic          bist_on,
  output logic          pass_start
);
  import bist_txgen_pkg::*;

  logic          en_q;
  logic [DW-1:0] usr_data_q;
  logic [1:0]    usr_ctl_q;
  phase_t        phase_q, phase_d;
  logic          first_q, first_d;

  logic [LW-1:0] lfsr_state;
  logic          lfsr_wrap, lfsr_load, lfsr_step;
  logic          pre_first, pre_last, pre_clr, pre_en;
  logic [DW-1:0] gen_code;
  logic [1:0]    gen_ctl;
  logic          in_pre, in_run, pass_end;

  assign in_pre   = en_q && (phase_q == PH_PRE);
  assign in_run   = en_q && (phase_q == PH_RUN);
  assign pass_end = in_run && lfsr_wrap;

  // generator control
  assign lfsr_load = !en_q;
  assign lfsr_step = in_run || (in_pre && pre_last);
  assign pre_clr   = !en_q || in_run;
  assign pre_en    = in_pre;

  bist_lfsr #(.W(LW), .TAP(TAP), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load_seed(lfsr_load), .step_en(lfsr_step),
    .state(lfsr_state), .wrap(lfsr_wrap)
  );

  bist_pre_cnt #(.LEN(PRE_LEN)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .cnt_en(pre_en),
    .first(pre_first), .last(pre_last)
  );

  bist_char_map #(.W(LW)) u_map (
    .state(lfsr_state), .code(gen_code), .ctl(gen_ctl)
  );

  // next state
  always_comb begin
    phase_d = phase_q;
    if (!en_q || pass_end)     phase_d = refclk_mode ? PH_PRE : PH_RUN;
    else if (in_pre && pre_last) phase_d = PH_RUN;
    first_d = !en_q || pass_end;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (cfg_we) en_q <= cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_data_q <= '0;
      usr_ctl_q  <= '0;
      phase_q    <= PH_RUN;
      first_q    <= 1'b1;
    end else begin
      usr_data_q <= usr_data;
      usr_ctl_q  <= usr_ctl;
      phase_q    <= phase_d;
      first_q    <= first_d;
    end
  end

  // output select
  always_comb begin
    if (!en_q) begin
      tx_char = usr_data_q;
      tx_ctl  = usr_ctl_q;
    end else if (phase_q == PH_PRE) begin
      tx_char = SYNC_CHAR;
      tx_ctl  = CTL_SYNC;
    end else begin
      tx_char = gen_code;
      tx_ctl  = gen_ctl;
    end
  end

  assign bist_on    = en_q;
  assign pass_start = en_q && first_q && (phase_q == PH_RUN || pre_first);
endmodule

// File: rtl/bist_txgen_chk.sv
module bist_txgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       cfg_en,
  input logic [7:0] usr_data,
  input logic [1:0] usr_ctl,
  input logic [7:0] tx_char,
  input logic [1:0] tx_ctl,
  input logic       bist_on,
  input logic       pass_start
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (bist_on == $past(cfg_en)));                          // R1
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(bist_on));                                   // R1
  AST_USER_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !bist_on) |-> (tx_char == $past(usr_data) && tx_ctl == $past(usr_ctl))); // R3
  AST_SYNC_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_on && tx_ctl == 2'b11) |-> (tx_char == 8'hBC));           // R7
  AST_START_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start |-> bist_on);                                         // R8
  AST_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_on) |-> pass_start);                                  // R9
endmodule

bind bist_txgen bist_txgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
  .usr_data(usr_data), .usr_ctl(usr_ctl), .tx_char(tx_char),
  .tx_ctl(tx_ctl), .bist_on(bist_on), .pass_start(pass_start)
);

// File: tb/sim_bist_txgen.sv
module sim_bist_txgen;
  logic       clk = 1'b0;
  logic       rst_n, cfg_we, cfg_en, refclk_mode;
  logic [7:0] usr_data;
  logic [1:0] usr_ctl;
  logic [7:0] tx_char;
  logic [1:0] tx_ctl;
  logic       bist_on, pass_start;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bist_txgen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .refclk_mode(refclk_mode), .usr_data(usr_data), .usr_ctl(usr_ctl),
    .tx_char(tx_char), .tx_ctl(tx_ctl), .bist_on(bist_on), .pass_start(pass_start)
  );

  // {usr_ctl, usr_data, expected tx_ctl, expected tx_char}
  localparam logic [19:0] VEC [0:7] = '{
    {2'b00, 8'h00, 2'b00, 8'h00}, {2'b11, 8'hFF, 2'b11, 8'hFF},
    {2'b01, 8'hA5, 2'b01, 8'hA5}, {2'b10, 8'h5A, 2'b10, 8'h5A},
    {2'b01, 8'h80, 2'b01, 8'h80}, {2'b10, 8'h01, 2'b10, 8'h01},
    {2'b00, 8'h3C, 2'b00, 8'h3C}, {2'b11, 8'hC3, 2'b11, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [8:0] nxt(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] m;
    logic [255:0] seen_d, seen_s;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_en = 1'b0; refclk_mode = 1'b0;
    usr_data = 8'h5A; usr_ctl = 2'b11;
    #10;
    // R2 reset state
    chk("R2 bist_on", bist_on, 0);
    chk("R2 tx_char", tx_char, 0);
    chk("R2 tx_ctl", tx_ctl, 0);
    chk("R2 pass_start", pass_start, 0);
    @(negedge clk); rst_n = 1'b1;
    tick();

    // R3 user path table
    for (int i = 0; i < 8; i++) begin
      {usr_ctl, usr_data} = VEC[i][19:10];
      tick();
      chk("R3 tx_char", tx_char, VEC[i][7:0]);
      chk("R3 tx_ctl", tx_ctl, VEC[i][9:8]);
    end
    // R1 no write: value on cfg_en ignored
    cfg_en = 1'b1;
    tick();
    chk("R1 no write", bist_on, 0);

    // R5 R6 plain pass with toggling user inputs (R4)
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
    chk("R1 write", bist_on, 1);
    m = 9'h001; seen_d = '0; seen_s = '0;
    for (int i = 0; i < 511; i++) begin
      chk("R5 char", tx_char, m[7:0]);
      chk("R5 ctl", tx_ctl, m[8] ? 2'b00 : 2'b10);
      chk("R8 pulse", pass_start, (i == 0));
      if (tx_ctl == 2'b00) seen_d[tx_char] = 1'b1;
      if (tx_ctl == 2'b10) seen_s[tx_char] = 1'b1;
      usr_data = 8'(i * 37); usr_ctl = 2'(i);
      m = nxt(m);
      tick();
    end
    chk("R6 data cover", $countones(seen_d), 256);
    chk("R6 spec cover", $countones(seen_s), 255);
    chk("R6 wrap char", tx_char, 8'h01);
    chk("R6 wrap start", pass_start, 1);
    chk("R4 ignore", tx_ctl, 2'b10);

    // R9 disable mid-pass
    repeat (5) tick();
    usr_data = 8'h33; usr_ctl = 2'b01;
    cfg_we = 1'b1; cfg_en = 1'b0;
    tick();
    cfg_we = 1'b0;
    chk("R9 off", bist_on, 0);
    chk("R9 user char", tx_char, 8'h33);
    chk("R9 user ctl", tx_ctl, 2'b01);

    // R7 preamble pass
    refclk_mode = 1'b1;
    tick();
    cfg_we = 1'b1; cfg_en = 1'b1;
    tick();
    cfg_we = 1'b0;
    for (int i = 0; i < 16; i++) begin
      chk("R7 sync ctl", tx_ctl, 2'b11);
      chk("R7 sync char", tx_char, 8'hBC);
      chk("R8 pre pulse", pass_start, (i == 0));
      usr_data = 8'(i * 11); usr_ctl = 2'(i);
      tick();
    end
    m = nxt(9'h001);
    for (int i = 0; i < 510; i++) begin
      chk("R7 char", tx_char, m[7:0]);
      chk("R7 ctl", tx_ctl, m[8] ? 2'b00 : 2'b10);
      chk("R8 pulse", pass_start, 0);
      m = nxt(m);
      tick();
    end
    chk("R7 526 wrap ctl", tx_ctl, 2'b11);
    chk("R7 526 wrap start", pass_start, 1);

    // R9 re-enable restarts from seed
    refclk_mode = 1'b0;
    cfg_we = 1'b1; cfg_en = 1'b0;
    tick();
    cfg_en = 1'b1;
    tick();
    cfg_we = 1'b0;
    chk("R9 restart char", tx_char, 8'h01);
    chk("R9 restart ctl", tx_ctl, 2'b10);
    chk("R9 restart pulse", pass_start, 1);
    tick();
    chk("R9 second char", tx_char, 8'h02);
    chk("R8 pulse low", pass_start, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule